// File: doc/BRIEF.md
# Serial Offset Register Port

This block holds the two threshold offsets a FIFO's flag logic needs: one sets the almost-empty distance and one sets the almost-full distance. Software or a board controller programs both through a single-bit serial path that runs on its own serial clock. The block keeps both values, drives them in parallel to the flag comparators, and can shift them back out for checking.

Every action happens on the rising edge of the serial clock. An active-low load enable shifts one bit from the serial input into the next storage position. An active-low read enable shifts the next stored bit out on the serial output. The serial stream is one unbroken sequence of 2*OFS_W bit positions. Each time readout is enabled again, it starts from the first position. A master reset sets both offsets to a default value. A partial reset rewinds the load and read positions and leaves the stored offsets as they are, so a FIFO pointer reset does not lose its programming.

Top module: `ofs_serial_port`

## Requirements
- R1: While `ld_n` is low, each rising `sclk` edge writes `sdi` into the current load position, and the position then advances by one. Positions 0..OFS_W-1 are `ae_ofs` bits 0..OFS_W-1, least-significant first. Positions OFS_W..2*OFS_W-1 are `af_ofs` bits 0..OFS_W-1.
- R2: After position 2*OFS_W-1 the load position wraps to 0, so further bits overwrite `ae_ofs` starting at bit 0.
- R3: While `ld_n` is high, `ae_ofs` and `af_ofs` do not change, whatever `sdi` and `rd_n` do.
- R4: While `rd_n` is low and `ld_n` is high, each rising `sclk` edge registers the stored bit at the current read position onto `sdo` and then advances the read position. The bit order is the same as in R1, and the position wraps after 2*OFS_W bits.
- R5: A rising `sclk` edge with `rd_n` high drives `sdo` to 0 and rewinds the read position to 0. The first read edge after `rd_n` falls therefore shows `ae_ofs` bit 0.
- R6: If `ld_n` and `rd_n` are both low, the load of R1 still takes place and `sdo` is driven to 0.
- R7: While `mrst_n` is low (asynchronous), `ae_ofs` and `af_ofs` both equal DEFAULT_OFS (127 by default), `sdo` is 0, and both positions are 0.
- R8: While `prst_n` is low (asynchronous), `sdo` is 0 and both positions return to 0. `ae_ofs` and `af_ofs` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all actions on its rising edge |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| ld_n | input | 1 | Load enable, active low |
| sdi | input | 1 | Serial data in |
| rd_n | input | 1 | Readout enable, active low |
| sdo | output | 1 | Serial data out, registered |
| ae_ofs | output | OFS_W | Almost-empty offset value |
| af_ofs | output | OFS_W | Almost-full offset value |

## Verification
A loaded bit reaches `ae_ofs`/`af_ofs` at the same rising edge that accepts it. A read bit, and the 0 that an idle or blocked read produces, reach `sdo` at the rising edge that requests them. Both resets act at once, without waiting for an edge. The bench therefore changes inputs on the falling edge and samples 5 ns after the next rising edge. It samples resets 1 ns after they are driven. It sweeps many offset patterns, reads each one back across the wrap point, and interleaves restarts, held loads, overlapping enables and both resets.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_READ = 2'd2
   } ofs_act_e;

   function automatic int pos_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ofs_bit_ptr.sv
module ofs_bit_ptr #(
   parameter int DEPTH = 32,
   parameter int PW    = ofs_pkg::pos_width(DEPTH)
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [PW-1:0] pos
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ofs_bit_ptr: DEPTH must be at least 2");
   end

   always_ff @(posedge clk or negedge mrst_n or negedge prst_n) begin
      if (!mrst_n)
         pos <= '0;
      else if (!prst_n)
         pos <= '0;
      else if (clr)
         pos <= '0;
      else if (adv)
         pos <= (pos == LAST) ? '0 : pos + 1'b1;
   end

   // wrap after the last position (R2, R4)
   assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (adv && !clr && pos == LAST) |=> (pos == '0));

   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (adv && !clr && pos != LAST) |=> (pos == $past(pos) + 1'b1));

   assert_ptr_rewind_R5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      clr |=> (pos == '0));

endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
   parameter int OFS_W       = 16,
   parameter int DEFAULT_OFS = 127,
   parameter int PW          = ofs_pkg::pos_width(2 * OFS_W)
) (
   input  logic                 clk,
   input  logic                 mrst_n,
   input  logic                 we,
   input  logic [PW-1:0]        sel,
   input  logic                 din,
   output logic [2*OFS_W-1:0]   bits
);

   localparam int NB = 2 * OFS_W;
   localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEFAULT_OFS);
   localparam logic [NB-1:0]    INIT  = {DEF_V, DEF_V};

   for (genvar i = 0; i < NB; i++) begin : g_cell
      logic q;
      always_ff @(posedge clk or negedge mrst_n) begin
         if (!mrst_n)
            q <= INIT[i];
         else if (we && sel == PW'(i))
            q <= din;
      end
      assign bits[i] = q;
   end

   // a written bit lands at the selected position (R1)
   assert_cell_write_R1: assert property (@(posedge clk) disable iff (!mrst_n)
      we |=> (bits[$past(sel)] == $past(din)));

   // nothing moves without a write (R3, R8)
   assert_cell_hold_R3: assert property (@(posedge clk) disable iff (!mrst_n)
      !we |=> $stable(bits));

endmodule

// File: rtl/ofs_serial_port.sv
module ofs_serial_port #(
   parameter int OFS_W       = 16,
   parameter int DEFAULT_OFS = 127
) (
   input  logic             sclk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic             ld_n,
   input  logic             sdi,
   input  logic             rd_n,
   output logic             sdo,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs
);
   import ofs_pkg::*;

   localparam int NB = 2 * OFS_W;
   localparam int PW = pos_width(NB);

   if (OFS_W < 2 || OFS_W > 30) begin : g_bad_width
      $error("ofs_serial_port: OFS_W must lie in 2..30");
   end
   if (DEFAULT_OFS < 0 || DEFAULT_OFS >= (1 << OFS_W)) begin : g_bad_default
      $error("ofs_serial_port: DEFAULT_OFS does not fit in OFS_W bits");
   end

   ofs_act_e        act;
   logic [PW-1:0]   wr_pos;
   logic [PW-1:0]   rd_pos;
   logic [NB-1:0]   bits;

   // load wins over readout (R6)
   always_comb begin
      if (!ld_n)
         act = ACT_LOAD;
      else if (!rd_n)
         act = ACT_READ;
      else
         act = ACT_IDLE;
   end

   ofs_bit_ptr #(.DEPTH(NB), .PW(PW)) u_wr_ptr (
      .clk    (sclk),
      .mrst_n (mrst_n),
      .prst_n (prst_n),
      .clr    (1'b0),
      .adv    (act == ACT_LOAD),
      .pos    (wr_pos)
   );

   ofs_bit_ptr #(.DEPTH(NB), .PW(PW)) u_rd_ptr (
      .clk    (sclk),
      .mrst_n (mrst_n),
      .prst_n (prst_n),
      .clr    (rd_n),
      .adv    (act == ACT_READ),
      .pos    (rd_pos)
   );

   ofs_store #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS), .PW(PW)) u_store (
      .clk    (sclk),
      .mrst_n (mrst_n),
      .we     (act == ACT_LOAD),
      .sel    (wr_pos),
      .din    (sdi),
      .bits   (bits)
   );

   always_ff @(posedge sclk or negedge mrst_n or negedge prst_n) begin
      if (!mrst_n)
         sdo <= 1'b0;
      else if (!prst_n)
         sdo <= 1'b0;
      else if (act == ACT_READ)
         sdo <= bits[rd_pos];
      else
         sdo <= 1'b0;
   end

   assign ae_ofs = bits[OFS_W-1:0];
   assign af_ofs = bits[NB-1:OFS_W];

   // load blocks the serial output (R6)
   assert_load_mutes_R6: assert property (@(posedge sclk) disable iff (!mrst_n || !prst_n)
      !ld_n |=> !sdo);

   // idle read enable keeps the output low (R5)
   assert_idle_low_R5: assert property (@(posedge sclk) disable iff (!mrst_n || !prst_n)
      rd_n |=> !sdo);

   // a fresh read starts from the first almost-empty bit (R5)
   assert_restart_first_R5: assert property (@(posedge sclk) disable iff (!mrst_n || !prst_n)
      rd_n |=> ((!rd_n && ld_n) |=> (sdo == $past(ae_ofs[0]))));

   // offsets keep still while loading is off (R3)
   assert_hold_offsets_R3: assert property (@(posedge sclk) disable iff (!mrst_n)
      ld_n |=> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

// File: tb/ofs_serial_port_test.sv
module ofs_serial_port_test;

   localparam int W   = 8;
   localparam int NB  = 2 * W;
   localparam int DEF = 127;

   logic sclk = 1'b0;
   logic mrst_n = 1'b0;
   logic prst_n = 1'b1;
   logic ld_n = 1'b1;
   logic sdi = 1'b0;
   logic rd_n = 1'b1;
   logic sdo;
   logic [W-1:0] ae_ofs;
   logic [W-1:0] af_ofs;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 sclk = ~sclk;

   ofs_serial_port #(.OFS_W(W), .DEFAULT_OFS(DEF)) uut (
      .sclk(sclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n),
      .sdi(sdi), .rd_n(rd_n), .sdo(sdo), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic l, input logic d, input logic r);
      @(negedge sclk);
      ld_n = l; sdi = d; rd_n = r;
      @(posedge sclk);
      #5;
   endtask

   task automatic load_word(input logic [NB-1:0] v, input logic r);
      for (int i = 0; i < NB; i++) begin
         step(1'b0, v[i], r);
         if (!r) chk("R6 sdo low while loading", sdo, 0);
      end
   endtask

   initial begin
      logic [NB-1:0] v;
      logic [NB-1:0] w;
      #45;
      chk("R7 reset ae", ae_ofs, DEF);
      chk("R7 reset af", af_ofs, DEF);
      chk("R7 reset sdo", sdo, 0);
      @(negedge sclk); mrst_n = 1'b1;

      // R1 / R4 sweep: load then read back across the wrap point
      for (int k = 0; k < 48; k++) begin
         v = NB'(k * 40503) ^ 16'h3c5a;
         load_word(v, 1'b1);
         chk("R1 ae value", ae_ofs, v[W-1:0]);
         chk("R1 af value", af_ofs, v[NB-1:W]);
         step(1'b1, 1'b0, 1'b1);
         chk("R5 sdo idle", sdo, 0);
         for (int i = 0; i < NB + 2; i++) begin
            step(1'b1, 1'b0, 1'b0);
            chk("R4 serial bit", sdo, v[i % NB]);
         end
      end

      // R5 restart after partial readout
      step(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
      chk("R4 fifth bit", sdo, v[4]);
      step(1'b1, 1'b0, 1'b1);
      chk("R5 sdo low on stop", sdo, 0);
      step(1'b1, 1'b0, 1'b0);
      chk("R5 restart bit0", sdo, v[0]);
      step(1'b1, 1'b0, 1'b0);
      chk("R5 restart bit1", sdo, v[1]);

      // R3 hold: sdi toggles, reads mixed, no load
      for (int i = 0; i < 12; i++) step(1'b1, 1'(i & 1), 1'((i % 3) != 0));
      chk("R3 ae held", ae_ofs, v[W-1:0]);
      chk("R3 af held", af_ofs, v[NB-1:W]);

      // R2 load wrap: three extra bits overwrite positions 0..2
      step(1'b1, 1'b0, 1'b1);
      load_word(16'h0f96, 1'b1);
      step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b1);
      w = 16'h0f96;
      w[2:0] = 3'b101;
      chk("R2 wrap ae", ae_ofs, w[W-1:0]);
      chk("R2 wrap af", af_ofs, w[NB-1:W]);

      // R8 partial reset keeps offsets, rewinds load position, mutes sdo
      step(1'b1, 1'b0, 1'b0);
      @(negedge sclk); ld_n = 1'b1; rd_n = 1'b1; prst_n = 1'b0;
      #1;
      chk("R8 sdo low", sdo, 0);
      chk("R8 ae kept", ae_ofs, w[W-1:0]);
      chk("R8 af kept", af_ofs, w[NB-1:W]);
      @(negedge sclk); @(negedge sclk); prst_n = 1'b1;
      chk("R8 ae kept after edges", ae_ofs, w[W-1:0]);
      load_word(16'hc3a5, 1'b1);
      chk("R8 load restarts ae", ae_ofs, 8'ha5);
      chk("R8 load restarts af", af_ofs, 8'hc3);

      // R6 both enables low: load goes on, sdo stays 0
      load_word(16'h5e21, 1'b0);
      chk("R6 ae loaded", ae_ofs, 8'h21);
      chk("R6 af loaded", af_ofs, 8'h5e);
      step(1'b1, 1'b0, 1'b0);
      chk("R6 read after overlap", sdo, 1'b1);

      // R7 master reset restores defaults
      @(negedge sclk); ld_n = 1'b1; rd_n = 1'b1; mrst_n = 1'b0;
      #1;
      chk("R7 ae default", ae_ofs, DEF);
      chk("R7 af default", af_ofs, DEF);
      chk("R7 sdo low", sdo, 0);
      @(negedge sclk); mrst_n = 1'b1;
      step(1'b1, 1'b0, 1'b0);
      chk("R7 read bit0 after reset", sdo, 1'b1);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule